// File: doc/BRIEF.md
# Framed Serial Register Loader

This block is a write-only serial slave. A host frames each 16-bit command word by holding an active-low frame-sync input low, and shifts the word in most significant bit first on the falling edges of its own serial clock. The shift logic runs on that serial clock. Each complete word goes to the system clock domain through a toggle handshake, where it is decoded and written to a register.

The decoder looks at the two top bits of the word. `00` is a control write. `01` and `10` are frequency writes to frequency register 0 and frequency register 1. `11` is a phase write to one of two 12-bit phase registers. Each frequency register is 28 bits wide and is built from 14-bit pieces. One control bit selects how this is done. In paired mode, two consecutive words to the same register load the low half and then the high half. In half mode, each word replaces only the upper or lower half, as a second control bit selects.

The outputs are the contents of every register and a one-cycle update strobe for each register, both in the system clock domain. The system clock must be fast enough that three of its cycles fit well within one 16-bit serial frame.

Top module: `serial_regload`

## Requirements
- R1: After reset, the control, frequency and phase outputs are all zero and no update strobe is pulsed.
- R2: A word is the 16 `sdata` values sampled on consecutive falling edges of `sclk` while `fsync_n` is low, first bit = bit 15. The result does not depend on whether `sclk` idles high or low between frames.
- R3: If `fsync_n` rises after fewer than 16 falling edges, the partial word is dropped. No register or strobe changes, and the next frame starts from bit 15.
- R4: Falling edges after the 16th one in the same frame are ignored. Only the first 16 bits form the word.
- R5: Bits [15:14]=`11` is a phase write. Bit 13 selects phase register 0 or 1, bit 12 is ignored, and bits [11:0] are stored in the selected register. The other phase register is unchanged.
- R6: Bits [15:14]=`00` is a control write. Bits [13:0] are stored and appear on `ctrl_word`.
- R7: Bits [15:14]=`01` addresses frequency register 0 and `10` addresses frequency register 1. Bits [13:0] are the 14-bit data.
- R8: When control bit 13 is 1 (paired mode), the first frequency word to a register is held as its low 14 bits and the register does not change. The next frequency word to the same register supplies bits [27:14], and the register then takes {second, first}.
- R9: A control write discards a held low half. In paired mode, a frequency word to the other register discards the held half and becomes that register's held low half.
- R10: When control bit 13 is 0 (half mode), a frequency word replaces bits [27:14] if control bit 12 is 1, or bits [13:0] if it is 0. The other half is kept.
- R11: Each completed register write pulses that register's strobe for exactly one system clock cycle. In paired mode only the second word pulses the strobe, and at most one strobe is high in any cycle.
- R12: A phase write does not disturb a held low half. A later matching frequency word still completes the pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock from the host; data sampled on its falling edge |
| fsync_n | input | 1 | Active-low frame sync; low while a word is shifted |
| sdata | input | 1 | Serial data, MSB first |
| ctrl_word | output | 14 | Control register contents |
| freq0_word | output | 28 | Frequency register 0 |
| freq1_word | output | 28 | Frequency register 1 |
| phase0_word | output | 12 | Phase register 0 |
| phase1_word | output | 12 | Phase register 1 |
| ctrl_upd | output | 1 | One-cycle strobe on a control write |
| freq_upd | output | 2 | One-cycle strobes, bit i for frequency register i |
| phase_upd | output | 2 | One-cycle strobes, bit i for phase register i |

## Verification
A sweep of phase values over both selects, with bit 12 toggled, shows that the select is decoded and that the ignored bit really is ignored. Half-mode writes alternate upper and lower halves on both frequency registers, which distinguishes a correct patch from a whole-register overwrite or a half swap. Paired sequences check the ordering of low and high halves and the hold-until-complete rule. Interleaved sequences (a write to the other register, a phase write, a control write between the halves) tell apart the rules for clearing and keeping the held half. Truncated frames, frames longer than 16 bits and both clock idle levels exercise the framing logic, and a strobe count compared after every word exposes missing, extra or stretched strobes.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int WORD_W  = 16;
  localparam int HALF_W  = 14;
  localparam int FREQ_W  = 2 * HALF_W;
  localparam int PHASE_W = 12;
  localparam int N_FREQ  = 2;
  localparam int N_PHASE = 2;
  // control bits with behavioural meaning
  localparam int PAIR_BIT  = HALF_W - 1;  // 1: two-word loading
  localparam int UPPER_BIT = HALF_W - 2;  // half mode: 1 selects upper half
  localparam int PSEL_BIT  = HALF_W - 1;  // phase register select in a phase word

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [HALF_W-1:0]  half_t;
  typedef logic [FREQ_W-1:0]  freq_t;
  typedef logic [PHASE_W-1:0] phase_t;

  typedef enum logic [1:0] {
    K_CTRL  = 2'b00,
    K_FREQ0 = 2'b01,
    K_FREQ1 = 2'b10,
    K_PHASE = 2'b11
  } word_kind_e;

  function automatic word_kind_e kind_of(input word_t w);
    return word_kind_e'(w[WORD_W-1:WORD_W-2]);
  endfunction

  function automatic freq_t join_pair(input half_t hi, input half_t lo);
    return {hi, lo};
  endfunction

  function automatic freq_t patch_half(input freq_t old, input half_t d, input logic upper);
    return upper ? {d, old[HALF_W-1:0]} : {old[FREQ_W-1:HALF_W], d};
  endfunction
endpackage

// File: rtl/srl_shift.sv
module srl_shift import srl_pkg::*; (
  input  logic  rst_n,
  input  logic  sclk,
  input  logic  fsync_n,
  input  logic  sdata,
  output word_t word_q,
  output logic  word_tog
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] sh;
  logic last_bit, frame_full;

  assign last_bit   = (bit_cnt == CNT_W'(WORD_W - 1));
  assign frame_full = (bit_cnt == CNT_W'(WORD_W));

  // bit counter and shifter: frame end clears the count at once
  always_ff @(negedge sclk or negedge rst_n or posedge fsync_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else if (fsync_n) begin
      bit_cnt <= '0;
    end else if (!frame_full) begin
      sh      <= {sh[WORD_W-3:0], sdata};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // completed word is held until the next one completes
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      word_tog <= 1'b0;
    end else if (!fsync_n && last_bit) begin
      word_q   <= {sh, sdata};
      word_tog <= ~word_tog;
    end
  end

  assert_cnt_bound_R4: assert property (@(negedge sclk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));
  assert_abort_clears_R3: assert property (@(negedge sclk) disable iff (!rst_n)
    fsync_n |-> bit_cnt == '0);
endmodule

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tog_in};
  end

  assign pulse = chain[STAGES] ^ chain[STAGES-1];

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/srl_freq_slot.sv
module srl_freq_slot import srl_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_pair,
  input  logic  load_half,
  input  logic  upper_sel,
  input  half_t data,
  input  half_t stage_lo,
  output freq_t value,
  output logic  upd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      upd   <= 1'b0;
    end else begin
      upd <= load_pair | load_half;
      if (load_pair)      value <= join_pair(data, stage_lo);
      else if (load_half) value <= patch_half(value, data, upper_sel);
    end
  end

  assert_upper_keeps_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_half && upper_sel) |=> value[HALF_W-1:0] == $past(value[HALF_W-1:0]));
  assert_lower_keeps_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_half && !upper_sel) |=> value[FREQ_W-1:HALF_W] == $past(value[FREQ_W-1:HALF_W]));
endmodule

// File: rtl/srl_regs.sv
module srl_regs import srl_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_ok,
  input  word_t              word,
  output half_t              ctrl,
  output freq_t              freq0,
  output freq_t              freq1,
  output phase_t             phase0,
  output phase_t             phase1,
  output logic               upd_ctrl,
  output logic [N_FREQ-1:0]  upd_freq,
  output logic [N_PHASE-1:0] upd_phase
);
  word_kind_e kind;
  half_t      data;
  logic       pair_mode, upper_sel;

  assign kind      = kind_of(word);
  assign data      = word[HALF_W-1:0];
  assign pair_mode = ctrl[PAIR_BIT];
  assign upper_sel = ctrl[UPPER_BIT];

  // named events
  logic                ev_ctrl;
  logic [N_FREQ-1:0]   ev_freq, pair_first, pair_second, half_write;
  logic [N_PHASE-1:0]  ev_phase;
  logic                pend_v, pend_idx;
  half_t               pend_lo;
  freq_t               freq_w  [N_FREQ];
  phase_t              phase_w [N_PHASE];

  assign ev_ctrl = word_ok && (kind == K_CTRL);

  for (genvar i = 0; i < N_FREQ; i++) begin : gen_freq
    assign ev_freq[i]     = word_ok && (kind == word_kind_e'(2'(i + 1)));
    assign pair_second[i] = ev_freq[i] && pair_mode && pend_v && (pend_idx == 1'(i));
    assign pair_first[i]  = ev_freq[i] && pair_mode && !(pend_v && (pend_idx == 1'(i)));
    assign half_write[i]  = ev_freq[i] && !pair_mode;

    srl_freq_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_pair (pair_second[i]),
      .load_half (half_write[i]),
      .upper_sel (upper_sel),
      .data      (data),
      .stage_lo  (pend_lo),
      .value     (freq_w[i]),
      .upd       (upd_freq[i])
    );

    assert_stage_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pair_first[i] |=> $stable(freq_w[i]));
  end

  for (genvar i = 0; i < N_PHASE; i++) begin : gen_phase
    phase_t q;
    logic   s;
    assign ev_phase[i] = word_ok && (kind == K_PHASE) && (word[PSEL_BIT] == 1'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        s <= 1'b0;
      end else begin
        s <= ev_phase[i];
        if (ev_phase[i]) q <= word[PHASE_W-1:0];
      end
    end
    assign phase_w[i]   = q;
    assign upd_phase[i] = s;

    assert_other_phase_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_phase[i] |=> $stable(phase_w[N_PHASE-1-i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      upd_ctrl <= 1'b0;
    end else begin
      upd_ctrl <= ev_ctrl;
      if (ev_ctrl) ctrl <= data;
    end
  end

  // two-word sequencer: holds one staged low half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_idx <= 1'b0;
      pend_lo  <= '0;
    end else if (ev_ctrl || (|pair_second)) begin
      pend_v <= 1'b0;
    end else if (|pair_first) begin
      pend_v   <= 1'b1;
      pend_idx <= pair_first[1];
      pend_lo  <= data;
    end
  end

  assign freq0  = freq_w[0];
  assign freq1  = freq_w[1];
  assign phase0 = phase_w[0];
  assign phase1 = phase_w[1];

  assert_ctrl_drops_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl |=> !pend_v);
  assert_phase_keeps_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_phase) |=> $stable(pend_v));
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_ctrl, upd_freq, upd_phase}));
endmodule

// File: rtl/serial_regload.sv
module serial_regload import srl_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               fsync_n,
  input  logic               sdata,
  output logic [HALF_W-1:0]  ctrl_word,
  output logic [FREQ_W-1:0]  freq0_word,
  output logic [FREQ_W-1:0]  freq1_word,
  output logic [PHASE_W-1:0] phase0_word,
  output logic [PHASE_W-1:0] phase1_word,
  output logic               ctrl_upd,
  output logic [N_FREQ-1:0]  freq_upd,
  output logic [N_PHASE-1:0] phase_upd
);
  word_t word_q;
  logic  word_tog, word_ok;

  srl_shift u_shift (
    .rst_n    (rst_n),
    .sclk     (sclk),
    .fsync_n  (fsync_n),
    .sdata    (sdata),
    .word_q   (word_q),
    .word_tog (word_tog)
  );

  srl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tog_in (word_tog),
    .pulse  (word_ok)
  );

  srl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_ok   (word_ok),
    .word      (word_q),
    .ctrl      (ctrl_word),
    .freq0     (freq0_word),
    .freq1     (freq1_word),
    .phase0    (phase0_word),
    .phase1    (phase1_word),
    .upd_ctrl  (ctrl_upd),
    .upd_freq  (freq_upd),
    .upd_phase (phase_upd)
  );
endmodule

// File: tb/serial_regload_test.sv
module serial_regload_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, fsync_n = 1'b1, sdata = 1'b0;
  logic [13:0] ctrl_word;
  logic [27:0] freq0_word, freq1_word;
  logic [11:0] phase0_word, phase1_word;
  logic ctrl_upd;
  logic [1:0] freq_upd, phase_upd;

  serial_regload uut (.*);

  always #4 clk = ~clk;

  int total = 0, fails = 0, cyc = 0, wide = 0;
  int got_cnt [5];
  int exp_cnt [5];
  logic [4:0] prev_s = '0;

  // strobe monitor: order ctrl, f0, f1, p0, p1
  always @(negedge clk) begin
    logic [4:0] s;
    s = {phase_upd[1], phase_upd[0], freq_upd[1], freq_upd[0], ctrl_upd};
    for (int k = 0; k < 5; k++) if (s[k]) got_cnt[k]++;
    if ((s & prev_s) != 0) wide++;
    prev_s = s;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      total++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // bench model
  logic [13:0] m_ctrl = '0;
  logic [27:0] m_freq [2];
  logic [11:0] m_phase [2];
  bit m_pend = 0;
  int m_pidx = 0;
  int m_lo = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input bit idle_hi, input int nbits);
    sclk = idle_hi; #20;
    fsync_n = 1'b0; #20;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdata = (i < 16) ? w[15-i] : 1'b1; #16;
      sclk = 1'b0; #16;
    end
    sclk = idle_hi; #16;
    fsync_n = 1'b1; sdata = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model(input logic [15:0] w);
    int top, d, k;
    top = int'(w[15:14]);
    d   = int'(w[13:0]);
    if (top == 0) begin
      m_ctrl = w[13:0]; m_pend = 0; exp_cnt[0]++;
    end else if (top == 3) begin
      k = int'(w[13]); m_phase[k] = w[11:0]; exp_cnt[3+k]++;
    end else begin
      k = top - 1;
      if (m_ctrl[13]) begin
        if (m_pend && m_pidx == k) begin
          m_freq[k] = 28'(d * 16384 + m_lo); m_pend = 0; exp_cnt[1+k]++;
        end else begin
          m_pend = 1; m_pidx = k; m_lo = d;
        end
      end else begin
        if (m_ctrl[12]) m_freq[k] = 28'(int'(m_freq[k]) % 16384 + d * 16384);
        else            m_freq[k] = 28'((int'(m_freq[k]) / 16384) * 16384 + d);
        exp_cnt[1+k]++;
      end
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "ctrl", 32'(ctrl_word), 32'(m_ctrl));
    chk(tag, "freq0", 32'(freq0_word), 32'(m_freq[0]));
    chk(tag, "freq1", 32'(freq1_word), 32'(m_freq[1]));
    chk(tag, "phase0", 32'(phase0_word), 32'(m_phase[0]));
    chk(tag, "phase1", 32'(phase1_word), 32'(m_phase[1]));
    chk(tag, "strobes", {got_cnt[4][5:0], got_cnt[3][5:0], got_cnt[2][5:0], got_cnt[1][5:0], got_cnt[0][5:0]},
                        {exp_cnt[4][5:0], exp_cnt[3][5:0], exp_cnt[2][5:0], exp_cnt[1][5:0], exp_cnt[0][5:0]});
  endtask

  task automatic put(input logic [15:0] w, input bit idle_hi, input int nbits, input string tag);
    send_frame(w, idle_hi, nbits);
    if (nbits >= 16) model(w);
    compare(tag);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin got_cnt[k] = 0; exp_cnt[k] = 0; end
    for (int k = 0; k < 2; k++) begin m_freq[k] = '0; m_phase[k] = '0; end
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");

    // R6 control write, R2 both idle levels
    put(16'h1555, 1'b0, 16, "R6");
    put(16'h0A5C, 1'b1, 16, "R2");

    // R10 half mode with R7 addressing, sweep data and halves
    for (int n = 0; n < 12; n++) begin
      logic [13:0] d;
      d = 14'((n * 5471 + 123) % 16384);
      put({2'b00, 2'b00, 1'b0, 11'(n)} | (n[0] ? 16'h1000 : 16'h0000), n[1], 16, "R10");
      put({2'b01, d}, n[2], 16, "R7");
      put({2'b10, ~d}, 1'b0, 16, "R10");
    end

    // R5 phase sweep, both selects, bit 12 toggled
    for (int v = 0; v < 4096; v += 199) begin
      put({2'b11, 1'b0, v[0], 12'(v)}, 1'b0, 16, "R5");
      put({2'b11, 1'b1, ~v[0], 12'(~v)}, 1'b1, 16, "R5");
    end

    // R8 paired mode
    put(16'h2000, 1'b0, 16, "R6");
    for (int n = 0; n < 8; n++) begin
      logic [13:0] lo, hi;
      lo = 14'((n * 3001 + 7) % 16384);
      hi = 14'((n * 9157 + 4099) % 16384);
      put({2'b01, lo}, 1'b0, 16, "R8");
      put({2'b01, hi}, 1'b1, 16, "R8");
      put({2'b10, hi}, 1'b0, 16, "R8");
      put({2'b10, lo}, 1'b0, 16, "R11");
    end

    // R12 phase write between halves
    put({2'b10, 14'h0123}, 1'b0, 16, "R12");
    put({2'b11, 2'b10, 12'hABC}, 1'b0, 16, "R12");
    put({2'b10, 14'h3210}, 1'b0, 16, "R12");

    // R9 other register restarts pairing
    put({2'b01, 14'h1111}, 1'b0, 16, "R9");
    put({2'b10, 14'h2222}, 1'b0, 16, "R9");
    put({2'b10, 14'h3333}, 1'b0, 16, "R9");
    put({2'b01, 14'h0444}, 1'b0, 16, "R9");
    // R9 control write drops a held half
    put(16'h2000, 1'b0, 16, "R9");
    put({2'b01, 14'h0555}, 1'b1, 16, "R9");
    put({2'b01, 14'h0666}, 1'b1, 16, "R9");

    // R3 partial frame then a full one
    put({2'b11, 2'b00, 12'hFFF}, 1'b0, 10, "R3");
    put({2'b11, 2'b00, 12'h5A5}, 1'b0, 7, "R3");
    put({2'b11, 2'b00, 12'h3C3}, 1'b1, 16, "R3");

    // R4 extra edges ignored
    put({2'b11, 2'b10, 12'h0F0}, 1'b0, 20, "R4");
    put(16'h0000, 1'b1, 19, "R4");
    put({2'b01, 14'h2AAA}, 1'b0, 16, "R4");

    chk("R11", "stretched strobes", 32'(wide), 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule